// File: doc/BRIEF.md
# Memory-Operand Multicycle Processor

This block is a small multicycle processor. It has sixteen 32-bit general registers and one shared, word-addressed memory port that makes at most one access per clock cycle. Every arithmetic instruction combines a register with a second operand. That operand is either a memory word or the computed effective address itself. The result goes back into the register or into the same memory word. The effective address comes from a selectable function of an index register and a zero-extended 17-bit address field. That function is drawn from the same function set as the ALU.

The core fetches one instruction word per instruction. It steps through decode, address formation, an optional operand read, execute and write-back, then fetches again from the next word. No branching takes place, and the program counter only increments. A reserved instruction class provides a no-op and a halt. After a halt the core makes no further memory accesses until it is reset. The memory attached to the port must return read data on the cycle after the request.

Top module: `memop_cpu`

## Requirements
- R1: While reset is high, the core clears the program counter and all sixteen registers and drops `halted`. On the first cycle after reset it requests a read of address 0.
- R2: Instruction word fields are laid out as follows: class in [31:30], function in [29:27], address mode in [26:25], target register in [24:21], index register in [20:17], and address/immediate field in [16:0]. The address/immediate field is zero-extended to 32 bits.
- R3: Function codes: 0 is add, 1 is subtract (register minus operand, modulo 2^32), 2 is bitwise AND, 3 is bitwise OR, 4 passes the register, 5 passes the operand. Codes 6 and 7 pass the register.
- R4: Address mode codes: 0 gives index register plus field, 1 gives index register only, 2 and 3 give field only. The low 16 bits of the result address memory.
- R5: Class 0 writes register op M[EA] into the target register and leaves memory unchanged.
- R6: Class 1 writes register op M[EA] back to address EA. The write goes to the same address that was read two cycles before.
- R7: Class 2 writes register op EA into the target register and makes no data memory access.
- R8: Each instruction makes exactly one fetch, and the program counter then increments by one. Class 0 makes 2 accesses in total, class 1 makes 3 and class 2 makes 1. A write enable never appears without a memory request.
- R9: Class 3 with function 7 raises `halted`. `halted` then stays high and no memory request is issued until reset. Class 3 with any other function is a no-op that changes no register or memory.
- R10: Read data is taken one cycle after the request. The cycle after a memory write is always the fetch of the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| halted | output | 1 | Core has stopped on a halt instruction |

## Verification
Register contents cannot be seen directly from the ports. Each instruction under test is therefore placed inside a short program. The program loads a wide value from memory into a register and forms a base address with an immediate instruction. It then runs the instruction under test and stores the target register with a pass-register store. The sweep covers every class, function and mode against two data patterns. It compares the stored word, the read-modify-write target and the total access count against values computed in the bench. The register-clearing effect of reset is the hardest case to observe: one program writes a register, the core is reset, and a second program stores that register.

// File: rtl/memop_pkg.sv
package memop_pkg;

  localparam int INSN_W = 32;
  localparam int FLD_W  = 17;
  localparam int RIDX_W = 4;

  typedef enum logic [1:0] {
    CL_MEM2REG = 2'd0,
    CL_REG2MEM = 2'd1,
    CL_IMM     = 2'd2,
    CL_SYS     = 2'd3
  } iclass_e;

  typedef enum logic [2:0] {
    FN_ADD   = 3'd0,
    FN_SUB   = 3'd1,
    FN_AND   = 3'd2,
    FN_OR    = 3'd3,
    FN_LEFT  = 3'd4,
    FN_RIGHT = 3'd5,
    FN_RSV6  = 3'd6,
    FN_HALT  = 3'd7
  } fn_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_ADDR,
    ST_MEMRD,
    ST_EXEC,
    ST_WB,
    ST_HALT
  } state_e;

  typedef struct packed {
    logic [1:0]        cls;
    logic [2:0]        fn;
    logic [1:0]        mode;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rx;
    logic [FLD_W-1:0]  fld;
  } insn_t;

  // address mode reuses the ALU function set
  function automatic logic [2:0] mode_fn(input logic [1:0] m);
    case (m)
      2'd0:    mode_fn = FN_ADD;
      2'd1:    mode_fn = FN_LEFT;
      default: mode_fn = FN_RIGHT;
    endcase
  endfunction

endpackage

// File: rtl/memop_alu.sv
module memop_alu
  import memop_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]   fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  always_comb begin
    case (fn)
      FN_ADD:   y = a + b;
      FN_SUB:   y = a - b;
      FN_AND:   y = a & b;
      FN_OR:    y = a | b;
      FN_RIGHT: y = b;
      default:  y = a;
    endcase
  end

endmodule

// File: rtl/memop_regfile.sv
module memop_regfile #(
  parameter int W     = 32,
  parameter int NREG  = 16,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra0,
  output logic [W-1:0]  rd0,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd0 = regs[ra0];
  assign rd1 = regs[ra1];

endmodule

// File: rtl/memop_ctrl.sv
module memop_ctrl
  import memop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cls,
  input  logic [2:0] fn,
  output logic       ld_ir,
  output logic       ld_ea,
  output logic       ld_res,
  output logic       rf_we,
  output logic       pc_inc,
  output logic       req,
  output logic       req_wr,
  output logic       sel_ea,
  output logic       halted
);

  state_e st, st_nx;

  always_comb begin
    st_nx  = st;
    ld_ir  = 1'b0;
    ld_ea  = 1'b0;
    ld_res = 1'b0;
    rf_we  = 1'b0;
    pc_inc = 1'b0;
    req    = 1'b0;
    req_wr = 1'b0;
    sel_ea = 1'b0;
    case (st)
      ST_FETCH: begin
        req    = 1'b1;
        pc_inc = 1'b1;
        st_nx  = ST_DECODE;
      end
      ST_DECODE: begin
        ld_ir = 1'b1;
        st_nx = ST_ADDR;
      end
      ST_ADDR: begin
        ld_ea = 1'b1;
        case (cls)
          CL_SYS:  st_nx = (fn == FN_HALT) ? ST_HALT : ST_FETCH;
          CL_IMM:  st_nx = ST_EXEC;
          default: st_nx = ST_MEMRD;
        endcase
      end
      ST_MEMRD: begin
        req    = 1'b1;
        sel_ea = 1'b1;
        st_nx  = ST_EXEC;
      end
      ST_EXEC: begin
        ld_res = 1'b1;
        st_nx  = ST_WB;
      end
      ST_WB: begin
        if (cls == CL_REG2MEM) begin
          req    = 1'b1;
          req_wr = 1'b1;
          sel_ea = 1'b1;
        end else begin
          rf_we = 1'b1;
        end
        st_nx = ST_FETCH;
      end
      default: st_nx = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_FETCH;
      halted <= 1'b0;
    end else begin
      st <= st_nx;
      if (st_nx == ST_HALT) halted <= 1'b1;
    end
  end

endmodule

// File: rtl/memop_cpu.sv
module memop_cpu
  import memop_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 16,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          halted
);

  localparam int EXT_W = DW - FLD_W;

  logic [AW-1:0] pc;
  logic [DW-1:0] ir, ea, res;
  insn_t         dec;

  logic ld_ir, ld_ea, ld_res, rf_we, pc_inc, sel_ea;
  logic [DW-1:0] r_tgt, r_idx, fld_ext, agu_y, alu_b, alu_y;

  assign dec     = insn_t'(ir[INSN_W-1:0]);
  assign fld_ext = {{EXT_W{1'b0}}, dec.fld};

  memop_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .cls    (dec.cls),
    .fn     (dec.fn),
    .ld_ir  (ld_ir),
    .ld_ea  (ld_ea),
    .ld_res (ld_res),
    .rf_we  (rf_we),
    .pc_inc (pc_inc),
    .req    (mem_en),
    .req_wr (mem_we),
    .sel_ea (sel_ea),
    .halted (halted)
  );

  memop_regfile #(.W(DW), .NREG(NREG)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (rf_we),
    .wa  (dec.rd),
    .wd  (res),
    .ra0 (dec.rd),
    .rd0 (r_tgt),
    .ra1 (dec.rx),
    .rd1 (r_idx)
  );

  // address unit: same function set, selected by the mode field
  memop_alu #(.W(DW)) u_agu (
    .fn (mode_fn(dec.mode)),
    .a  (r_idx),
    .b  (fld_ext),
    .y  (agu_y)
  );

  assign alu_b = (dec.cls == CL_IMM) ? ea : mem_rdata;

  memop_alu #(.W(DW)) u_alu (
    .fn (dec.fn),
    .a  (r_tgt),
    .b  (alu_b),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ir  <= '0;
      ea  <= '0;
      res <= '0;
    end else begin
      if (pc_inc) pc  <= pc + 1'b1;
      if (ld_ir)  ir  <= mem_rdata;
      if (ld_ea)  ea  <= agu_y;
      if (ld_res) res <= alu_y;
    end
  end

  assign mem_addr  = sel_ea ? ea[AW-1:0] : pc;
  assign mem_wdata = res;

endmodule

// File: rtl/memop_cpu_chk.sv
module memop_cpu_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          halted
);

  a_r1_first_fetch: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_en && !mem_we && mem_addr == '0));

  a_r8_we_needs_req: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  a_r6_rmw_same_addr: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(mem_en, 2) && !$past(mem_we, 2) && $past(mem_addr, 2) == mem_addr));

  a_r10_fetch_after_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (mem_en && !mem_we));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_en);

endmodule

bind memop_cpu memop_cpu_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_en   (mem_en),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .halted   (halted)
);

// File: tb/memop_cpu_bench.sv
`timescale 1ns/1ps
module memop_cpu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_en, mem_we, halted;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic        pl_en = 1'b0;
  logic [11:0] pl_addr = '0;
  logic [31:0] pl_data = '0;
  logic [31:0] mem [4096];
  int          acc;
  int          nchk = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  memop_cpu u_memop_cpu (
    .clk(clk), .rst(rst), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted)
  );

  always @(posedge clk) begin
    if (pl_en) mem[pl_addr] <= pl_data;
    else if (mem_en) begin
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:0]];
    end
  end

  always @(posedge clk) begin
    if (rst) acc <= 0;
    else if (mem_en) acc <= acc + 1;
  end

  function automatic logic [31:0] enc(int c, int f, int m, int rd, int rx, int fld);
    enc = {c[1:0], f[2:0], m[1:0], rd[3:0], rx[3:0], fld[16:0]};
  endfunction

  function automatic logic [31:0] f_op(int f, logic [31:0] a, logic [31:0] b);
    case (f)
      0: f_op = a + b;
      1: f_op = a - b;
      2: f_op = a & b;
      3: f_op = a | b;
      5: f_op = b;
      default: f_op = a;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(int a, logic [31:0] d);
    pl_en = 1'b1; pl_addr = a[11:0]; pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  // release reset, run to halt, return the access count
  task automatic run(output int n_acc);
    int cyc;
    rst = 1'b0;
    #0.5;
    check("R1 first fetch request", {31'b0, mem_en}, 32'd1);
    check("R1 first fetch addr", {16'b0, mem_addr}, 32'd0);
    check("R1 halted clear", {31'b0, halted}, 32'd0);
    @(negedge clk);
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    check("R9 halt reached", {31'b0, halted}, 32'd1);
    n_acc = acc;
    repeat (8) @(negedge clk);
    check("R9 no access after halt", acc, n_acc);
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int n;
    logic [31:0] av [2];
    logic [31:0] dv [2];
    av[0] = 32'h8000_0003; dv[0] = 32'h7FFF_FFFD;
    av[1] = 32'h0000_1234; dv[1] = 32'hFFFF_F0F0;

    // R1: reset clears registers: dirty R7, reset, store it
    enter_reset();
    poke(0, enc(2, 5, 2, 7, 0, 123));
    poke(1, enc(3, 7, 0, 0, 0, 0));
    run(n);
    enter_reset();
    poke(0, enc(1, 4, 2, 7, 0, 900));
    poke(1, enc(3, 7, 0, 0, 0, 0));
    poke(900, 32'h55);
    run(n);
    check("R1 register cleared by reset", mem[900], 32'h0);
    check("R8 access count store+halt", n, 32'd4);

    // R2/R7: maximum field zero-extended
    enter_reset();
    poke(0, enc(2, 5, 2, 2, 0, 17'h1FFFF));
    poke(1, enc(1, 4, 2, 2, 0, 900));
    poke(2, enc(3, 7, 0, 0, 0, 0));
    run(n);
    check("R2 field zero-extended", mem[900], 32'h0001_FFFF);
    check("R7 immediate access count", n, 32'd5);

    // sweep: class x function x mode x data pattern
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 3; c++)
        for (int f = 0; f < 8; f++)
          for (int m = 0; m < 4; m++) begin
            int ea;
            logic [31:0] exp_st, exp_ea;
            ea = (m == 0) ? 1240 : (m == 1) ? 1200 : 40;
            enter_reset();
            poke(0, enc(0, 5, 2, 1, 0, 800));   // R1 = M[800]
            poke(1, enc(2, 5, 2, 3, 0, 1200));  // R3 = 1200
            poke(2, enc(3, 2, 1, 5, 5, 77));    // class 3 no-op
            poke(3, enc(c, f, m, 1, 3, 40));    // under test
            poke(4, enc(1, 4, 2, 1, 0, 900));   // M[900] = R1
            poke(5, enc(3, 7, 0, 0, 0, 0));     // halt
            poke(800, av[p]);
            poke(900, 32'h0);
            poke(40, 32'h0);
            poke(1200, 32'h0);
            poke(1240, 32'h0);
            poke(ea, dv[p]);
            run(n);
            case (c)
              0: begin
                exp_st = f_op(f, av[p], dv[p]);
                check("R5 R3 R4 mem-to-reg result", mem[900], exp_st);
                check("R5 memory untouched", mem[ea], dv[p]);
                check("R8 R10 access count class 0", n, 32'd10);
              end
              1: begin
                exp_ea = f_op(f, av[p], dv[p]);
                check("R6 R3 R4 reg-to-mem result", mem[ea], exp_ea);
                check("R6 R9 register unchanged", mem[900], av[p]);
                check("R8 access count class 1", n, 32'd11);
              end
              default: begin
                exp_st = f_op(f, av[p], ea);
                check("R7 R3 R4 immediate result", mem[900], exp_st);
                check("R7 no data access", mem[ea], dv[p]);
                check("R8 access count class 2", n, 32'd9);
              end
            endcase
          end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=halt");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule